// File: doc/BRIEF.md
# FIFO-to-SCSI DMA Handshake Controller

This block feeds words from an external first-in first-out buffer into the DMA data port of a SCSI protocol controller chip. The protocol chip raises a request line whenever its own small internal buffer (sixteen words deep) has room, so requests come in bursts and pause when that buffer fills. The block answers a request with an acknowledge pulse only when the external buffer reports that it holds data. Each acknowledge comes with a read strobe that pops the external buffer and a registered copy of the word that stays stable on the data port.

A host processor controls each transfer. It loads a byte count, starts the transfer, and can clear status, abort a transfer that has gone wrong, or soft-reset the block. The count runs down by the bus width in bytes for every word granted. When it reaches zero the transfer ends and a sticky completion flag is raised. An abort ends the transfer early and raises a separate sticky flag. The remaining count can be read on an output.

Top module: `fifo_scsi_dma`

## Requirements
- R1: After `rst_n` is asserted low, `dack` and `fifo_rd` are 0, `done` and `aborted` are 0, `xfer_left` is 0, and the block is idle, so requests are not answered.
- R2: While a transfer is active, if a clock edge samples `dreq`=1 and `fifo_empty`=0, then `dack` and `fifo_rd` are both 1 during the next cycle. In every other case they stay 0.
- R3: `dack` is never high for two cycles in a row. A grant cycle is always followed by at least one cycle with `dack`=0, so at most one word is granted every two cycles.
- R4: At the edge that starts a grant, `dma_data` captures `fifo_data`. `dma_data` does not change in any cycle in which `dack` is 0.
- R5: Each grant lowers `xfer_left` by DATA_W/8 bytes (2 with the default 16-bit bus). If fewer bytes than that remain, it drops to 0 instead. Without a grant, an accepted load or a soft reset, `xfer_left` does not change.
- R6: If `dreq`=1 while `fifo_empty`=1, there is no grant and the count is kept. The transfer resumes as soon as the buffer is no longer empty.
- R7: When a grant brings the count to zero, `done` becomes 1 in the cycle after the grant cycle. The block then goes idle, and any later `dreq` is ignored.
- R8: A start with a count of zero sets `done` one cycle later and produces no grant.
- R9: `host_abort` during an active transfer returns the block to idle at the next edge. It takes priority over a grant in the same cycle, sets `aborted`, and keeps `xfer_left`. In idle it has no effect.
- R10: `done` and `aborted` hold until `host_clear`, an accepted load or an accepted start clears them. `host_load` and `host_start` are accepted only when the block is idle and are ignored during a transfer.
- R11: `host_reset` is a synchronous soft reset. At the next edge it makes the block idle, clears the count and both flags, and ends any grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_reset | input | 1 | Synchronous soft reset from the host |
| host_load | input | 1 | Load `host_count` into the byte counter (idle only) |
| host_count | input | CNT_W | Byte count for the next transfer |
| host_start | input | 1 | Begin a transfer using the loaded count (idle only) |
| host_abort | input | 1 | End an active transfer early |
| host_clear | input | 1 | Clear the sticky status flags |
| dreq | input | 1 | Data request from the protocol chip |
| fifo_empty | input | 1 | External buffer holds no data |
| fifo_data | input | DATA_W | Head word of the external buffer |
| dack | output | 1 | Registered acknowledge to the protocol chip |
| fifo_rd | output | 1 | Registered pop strobe to the external buffer |
| dma_data | output | DATA_W | Registered word presented to the protocol chip |
| xfer_left | output | CNT_W | Bytes still to move |
| done | output | 1 | Sticky completion flag |
| aborted | output | 1 | Sticky abort flag |

## Verification
Some properties are checked on every cycle. An acknowledge is always preceded by a request and a non-empty buffer, never lasts two cycles, and never coincides with completion. The data port changes only at the start of a grant. The count steps by exactly one word per grant and is otherwise steady. An abort during a transfer always empties the handshake at once.

Other behaviour only shows up over several cycles, so the bench scenarios cover it. These include the ordered burst with a stall and a resume, completion on the last word, an odd count clamping to zero, a start with zero count, and a load ignored while busy. They also cover the soft reset and the flags holding or clearing under host commands.

// File: rtl/fsdma_pkg.sv
package fsdma_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_STALL = 2'd2,
      ST_GRANT = 2'd3
   } dma_st_e;

endpackage

// File: rtl/fsdma_bytecnt.sv
module fsdma_bytecnt #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic [CNT_W-1:0] count,
   output logic             is_zero
);
   localparam int               STEP   = DATA_W / 8;
   localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_dec;

   generate
      if (STEP == 1) begin : g_unit_step
         assign cnt_dec = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
      end else begin : g_wide_step
         assign cnt_dec = (cnt_q > STEP_V) ? cnt_q - STEP_V : '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (soft_rst) cnt_q <= '0;
      else if (load)     cnt_q <= load_val;
      else if (dec)      cnt_q <= cnt_dec;
   end

   assign count   = cnt_q;
   assign is_zero = (cnt_q == '0);

endmodule

// File: rtl/fsdma_ctrl.sv
module fsdma_ctrl
   import fsdma_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              host_start,
   input  logic              host_load,
   input  logic              host_abort,
   input  logic              dreq,
   input  logic              fifo_empty,
   input  logic [DATA_W-1:0] fifo_data,
   input  logic              cnt_zero,
   output logic              idle,
   output logic              grant_go,
   output logic              fin,
   output logic              start_hit,
   output logic              abort_hit,
   output logic              dack,
   output logic              fifo_rd,
   output logic [DATA_W-1:0] dma_data
);
   dma_st_e           st_q, st_d;
   logic              dack_q;
   logic              rd_q;
   logic [DATA_W-1:0] data_q;
   logic              req_ok;

   assign idle      = (st_q == ST_IDLE);
   assign req_ok    = dreq & ~fifo_empty;
   assign start_hit = idle & host_start & ~host_load & ~soft_rst;
   assign abort_hit = ~idle & host_abort & ~soft_rst;

   always_comb begin
      st_d     = st_q;
      grant_go = 1'b0;
      fin      = 1'b0;
      if (soft_rst || abort_hit) begin
         st_d = ST_IDLE;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start_hit) begin
                  if (cnt_zero) fin  = 1'b1;
                  else          st_d = ST_WAIT;
               end
            end
            ST_WAIT, ST_STALL: begin
               if (req_ok) begin
                  st_d     = ST_GRANT;
                  grant_go = 1'b1;
               end else if (dreq) begin
                  st_d = ST_STALL;
               end else begin
                  st_d = ST_WAIT;
               end
            end
            ST_GRANT: begin
               if (cnt_zero) begin
                  st_d = ST_IDLE;
                  fin  = 1'b1;
               end else begin
                  st_d = ST_WAIT;
               end
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         dack_q <= 1'b0;
         rd_q   <= 1'b0;
      end else begin
         st_q   <= st_d;
         dack_q <= grant_go;
         rd_q   <= grant_go;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        data_q <= '0;
      else if (grant_go) data_q <= fifo_data;
   end

   assign dack     = dack_q;
   assign fifo_rd  = rd_q;
   assign dma_data = data_q;

endmodule

// File: rtl/fsdma_flags.sv
module fsdma_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic clr,
   input  logic fin,
   input  logic abort_hit,
   output logic done,
   output logic aborted
);
   logic done_q;
   logic abrt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         abrt_q <= 1'b0;
      end else if (soft_rst) begin
         done_q <= 1'b0;
         abrt_q <= 1'b0;
      end else begin
         done_q <= fin       | (done_q & ~clr);
         abrt_q <= abort_hit | (abrt_q & ~clr);
      end
   end

   assign done    = done_q;
   assign aborted = abrt_q;

endmodule

// File: rtl/fifo_scsi_dma.sv
module fifo_scsi_dma #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_reset,
   input  logic              host_load,
   input  logic [CNT_W-1:0]  host_count,
   input  logic              host_start,
   input  logic              host_abort,
   input  logic              host_clear,
   input  logic              dreq,
   input  logic              fifo_empty,
   input  logic [DATA_W-1:0] fifo_data,
   output logic              dack,
   output logic              fifo_rd,
   output logic [DATA_W-1:0] dma_data,
   output logic [CNT_W-1:0]  xfer_left,
   output logic              done,
   output logic              aborted
);
   localparam int STEP = DATA_W / 8;

   generate
      if ((DATA_W < 8) || (DATA_W % 8 != 0)) begin : g_bad_width
         $error("fifo_scsi_dma: DATA_W must be a positive multiple of 8");
      end
      if (CNT_W <= $clog2(STEP + 1)) begin : g_bad_count
         $error("fifo_scsi_dma: CNT_W too narrow for one word step");
      end
   endgenerate

   logic ctrl_idle;
   logic grant_go;
   logic fin;
   logic start_hit;
   logic abort_hit;
   logic cnt_zero;
   logic load_ok;
   logic flag_clr;

   assign load_ok  = host_load & ctrl_idle & ~host_reset;
   assign flag_clr = host_clear | load_ok | start_hit;

   fsdma_bytecnt #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (host_reset),
      .load     (load_ok),
      .load_val (host_count),
      .dec      (grant_go),
      .count    (xfer_left),
      .is_zero  (cnt_zero)
   );

   fsdma_ctrl #(
      .DATA_W (DATA_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (host_reset),
      .host_start (host_start),
      .host_load  (host_load),
      .host_abort (host_abort),
      .dreq       (dreq),
      .fifo_empty (fifo_empty),
      .fifo_data  (fifo_data),
      .cnt_zero   (cnt_zero),
      .idle       (ctrl_idle),
      .grant_go   (grant_go),
      .fin        (fin),
      .start_hit  (start_hit),
      .abort_hit  (abort_hit),
      .dack       (dack),
      .fifo_rd    (fifo_rd),
      .dma_data   (dma_data)
   );

   fsdma_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (host_reset),
      .clr       (flag_clr),
      .fin       (fin),
      .abort_hit (abort_hit),
      .done      (done),
      .aborted   (aborted)
   );

endmodule

// File: rtl/fsdma_chk.sv
module fsdma_chk #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_reset,
   input logic              host_load,
   input logic              host_abort,
   input logic              dreq,
   input logic              fifo_empty,
   input logic              dack,
   input logic [DATA_W-1:0] dma_data,
   input logic [CNT_W-1:0]  xfer_left,
   input logic              done,
   input logic              aborted,
   input logic              idle
);
   localparam logic [CNT_W-1:0] STEP_V = CNT_W'(DATA_W / 8);

   // R2: a grant needs a request and data at the deciding edge
   p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dack |-> ($past(dreq) && !$past(fifo_empty)));

   // R3: no two grant cycles back to back
   p_single_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dack |=> !dack);

   // R4: the data port moves only at the start of a grant
   p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !dack |-> $stable(dma_data));

   // R5: one word step per grant
   p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dack |-> (xfer_left == (($past(xfer_left) > STEP_V) ?
                              ($past(xfer_left) - STEP_V) : '0)));

   // R5: count is steady without grant, load or soft reset
   p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!dack && !$past(host_load) && !$past(host_reset)) |-> $stable(xfer_left));

   // R6: an empty buffer blocks the next grant
   p_empty_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |=> !dack);

   // R7: completion and grant never overlap
   p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !dack);

   // R9: abort during a transfer ends the handshake at once
   p_abort_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_abort && !idle && !host_reset) |=> (!dack && aborted && idle));

endmodule

bind fifo_scsi_dma fsdma_chk #(
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W)
) u_fsdma_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_reset (host_reset),
   .host_load  (host_load),
   .host_abort (host_abort),
   .dreq       (dreq),
   .fifo_empty (fifo_empty),
   .dack       (dack),
   .dma_data   (dma_data),
   .xfer_left  (xfer_left),
   .done       (done),
   .aborted    (aborted),
   .idle       (ctrl_idle)
);

// File: tb/fifo_scsi_dma_bench.sv
module fifo_scsi_dma_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int CW = 24;

   // row: {dreq, fifo_empty, exp_dack, exp_done, exp_left[3:0]}
   localparam logic [7:0] VEC [16] = '{
      8'b0000_1010, 8'b1010_1000, 8'b1000_1000, 8'b1100_1000,
      8'b1100_1000, 8'b1010_0110, 8'b0000_0110, 8'b0000_0110,
      8'b1010_0100, 8'b1000_0100, 8'b1010_0010, 8'b1000_0010,
      8'b0100_0010, 8'b1010_0000, 8'b1001_0000, 8'b1001_0000
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_reset = 1'b0;
   logic          host_load = 1'b0;
   logic [CW-1:0] host_count = '0;
   logic          host_start = 1'b0;
   logic          host_abort = 1'b0;
   logic          host_clear = 1'b0;
   logic          dreq = 1'b0;
   logic          fifo_empty = 1'b1;
   logic [DW-1:0] fifo_data = '0;
   logic          dack;
   logic          fifo_rd;
   logic [DW-1:0] dma_data;
   logic [CW-1:0] xfer_left;
   logic          done;
   logic          aborted;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fifo_scsi_dma #(.DATA_W(DW), .CNT_W(CW)) u_fifo_scsi_dma (
      .clk, .rst_n, .host_reset, .host_load, .host_count, .host_start,
      .host_abort, .host_clear, .dreq, .fifo_empty, .fifo_data,
      .dack, .fifo_rd, .dma_data, .xfer_left, .done, .aborted
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic load_count(input int n);
      host_load = 1'b1; host_count = CW'(n);
      tick();
      host_load = 1'b0;
   endtask

   task automatic start_xfer();
      host_start = 1'b1;
      tick();
      host_start = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      dreq = 1'b1; fifo_empty = 1'b0;
      rst_n = 1'b1;
      tick();
      check("R1 dack", dack, 0);
      check("R1 fifo_rd", fifo_rd, 0);
      check("R1 done", done, 0);
      check("R1 aborted", aborted, 0);
      check("R1 left", xfer_left, 0);
      dreq = 1'b0; fifo_empty = 1'b1;

      // table walk: 10-byte burst with stall, resume and completion
      load_count(10);
      start_xfer();
      for (int i = 0; i < 16; i++) begin
         dreq       = VEC[i][7];
         fifo_empty = VEC[i][6];
         fifo_data  = DW'(16'hA000 + i);
         tick();
         check($sformatf("R2 R3 R6 dack row%0d", i), dack, VEC[i][5]);
         check($sformatf("R4 fifo_rd row%0d", i), fifo_rd, VEC[i][5]);
         check($sformatf("R5 left row%0d", i), xfer_left, VEC[i][3:0]);
         check($sformatf("R7 done row%0d", i), done, VEC[i][4]);
         if (VEC[i][5])
            check($sformatf("R4 data row%0d", i), dma_data, 16'hA000 + i);
      end
      dreq = 1'b0;

      // R10: clear drops done
      host_clear = 1'b1; tick(); host_clear = 1'b0;
      check("R10 clear done", done, 0);

      // R8: start with zero count
      start_xfer();
      check("R8 done", done, 1);
      check("R8 dack", dack, 0);
      dreq = 1'b1; fifo_empty = 1'b0;
      tick();
      check("R7 idle ignores dreq", dack, 0);
      dreq = 1'b0;

      // R5: odd count clamps to zero
      load_count(3);
      check("R10 load clears done", done, 0);
      check("R5 load value", xfer_left, 3);
      start_xfer();
      dreq = 1'b1; fifo_empty = 1'b0; fifo_data = 16'h5A5A;
      tick();
      check("R5 odd first", xfer_left, 1);
      check("R2 odd dack", dack, 1);
      tick();
      check("R3 gap", dack, 0);
      tick();
      check("R5 odd clamp", xfer_left, 0);
      tick();
      check("R7 odd done", done, 1);
      check("R7 odd dack", dack, 0);
      dreq = 1'b0;

      // R9: abort wins over a grant in the same cycle
      load_count(8);
      start_xfer();
      dreq = 1'b1; fifo_empty = 1'b0; host_abort = 1'b1;
      tick();
      host_abort = 1'b0;
      check("R9 no dack", dack, 0);
      check("R9 aborted", aborted, 1);
      check("R9 left kept", xfer_left, 8);
      tick();
      check("R9 idle after abort", dack, 0);
      dreq = 1'b0;

      // R9: abort in idle does nothing
      host_clear = 1'b1; tick(); host_clear = 1'b0;
      check("R10 clear aborted", aborted, 0);
      host_abort = 1'b1; tick(); host_abort = 1'b0;
      check("R9 idle abort", aborted, 0);

      // R10: load ignored while busy
      load_count(8);
      start_xfer();
      load_count(20);
      check("R10 busy load", xfer_left, 8);
      dreq = 1'b1; fifo_empty = 1'b0;
      tick();
      check("R10 still active", dack, 1);
      check("R5 busy step", xfer_left, 6);
      dreq = 1'b0;

      // R11: soft reset mid-transfer
      host_reset = 1'b1; tick(); host_reset = 1'b0;
      check("R11 left", xfer_left, 0);
      check("R11 dack", dack, 0);
      check("R11 done", done, 0);
      dreq = 1'b1; fifo_empty = 1'b0;
      tick();
      check("R11 idle", dack, 0);
      dreq = 1'b0;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule